// File: doc/BRIEF.md
# ADC Test-Pattern Checker

This block sits after the deserializer of a converter receive path. It compares every received sample with the test pattern that the converter has been set to send. It helps find bits in the wrong order, capture-timing errors that make single bits flicker, and a wrong word boundary. A sample arrives with a valid strobe. A pattern-select input names the pattern to check against. The supported patterns are:

- a word that alternates with its complement,
- an incrementing ramp,
- a constant word supplied on an input,
- a single one that rotates through every bit position.

The checker does not need to know the starting phase of the pattern. The first valid sample after reset, or after the pattern selection changes, seeds the expected sequence. Checking begins with the sample that follows. From then on the expected value advances from its own previous value, not from the received one. So a single corrupted sample produces exactly one error and does not shift the rest of the sequence.

Three results are reported:

- a one-cycle mismatch flag for each checked sample that deviates;
- a sticky per-bit error mask that collects every bit position ever seen wrong;
- a saturating count of erroneous samples.

Random flicker errors spread across the mask over time. A bit that leads the ramp by one cycle marks only its own position.

Top module: `adc_pattern_checker`

## Requirements
- R1: After reset the mismatch flag, the error mask and the error count are all zero.
- R2: The first valid sample after reset, or after pat_sel takes a new value, is not checked. It only seeds the expected sequence, and the mismatch flag stays low for it.
- R3: With pat_sel = 0 (alternating), each expected sample is the bitwise complement of the previous expected sample.
- R4: With pat_sel = 1 (ramp), each expected sample is the previous expected sample plus one. All ones is followed by zero.
- R5: With pat_sel = 2 (constant), every checked sample is compared with the fixed_word input.
- R6: With pat_sel = 3 (walking one), each expected sample is the previous one rotated left by one position. The top bit wraps into bit 0.
- R7: The mismatch flag is high in the cycle after a checked sample that differs from its expected value, and low in every other cycle.
- R8: err_mask is the bitwise OR of (expected XOR received) over all checked samples since reset or clear. A ramp bit that changes one cycle early sets exactly that bit's position.
- R9: err_count increases by one for each mismatching checked sample and holds at its all-ones value instead of wrapping.
- R10: A high clr zeroes err_mask and err_count at the next edge and takes priority over that cycle's errors. It does not disturb the locked expected sequence.
- R11: After a mismatch the expected sequence continues from the expected value, so a single corrupted sample yields one error only.
- R12: A cycle with smp_valid low neither checks nor advances the expected sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_sel | input | 2 | Pattern: 0 alternating, 1 ramp, 2 constant, 3 walking one |
| fixed_word | input | SAMPLE_W | Word expected in constant mode |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Received sample |
| clr | input | 1 | Clears error mask and count |
| mismatch | output | 1 | Previous checked sample deviated |
| err_mask | output | SAMPLE_W | Sticky per-bit error positions |
| err_count | output | CNT_W | Saturating count of erroneous samples |

## Verification
On every cycle the assertions check four things:

- the error mask only gains bits unless a clear arrives;
- the count moves by at most one, and only together with a raised mismatch flag;
- the count holds at its ceiling;
- a clear empties both the mask and the count, and no mismatch follows a cycle without a sample.

Only the bench scenarios can show that each pattern's expected sequence is right. This covers the ramp wrap, the rotation of the walking one, the seeding after a pattern change, and the way one corrupted sample leaves the lock intact. It also covers which mask bits a ramp fault with an early bit sets.

// File: rtl/adc_pat_pkg.sv
package adc_pat_pkg;

    typedef enum logic [1:0] {
        PAT_ALT   = 2'd0,
        PAT_RAMP  = 2'd1,
        PAT_CONST = 2'd2,
        PAT_WALK  = 2'd3
    } pat_e;

    localparam int PAT_SEL_W = 2;

endpackage

// File: rtl/adc_pat_expect.sv
module adc_pat_expect
    import adc_pat_pkg::*;
#(
    parameter int SAMPLE_W = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  pat_e                pat_sel,
    input  logic [SAMPLE_W-1:0] fixed_word,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                chk_en,
    output logic [SAMPLE_W-1:0] exp_word
);

    logic                locked_q;
    pat_e                pat_q;
    logic [SAMPLE_W-1:0] exp_q;
    logic                lock_live;
    logic [SAMPLE_W-1:0] base;
    logic [SAMPLE_W-1:0] nxt;

    // Lock is lost as soon as the selection differs from last cycle's.
    assign lock_live = locked_q && (pat_sel == pat_q);
    assign exp_word  = (pat_sel == PAT_CONST) ? fixed_word : exp_q;
    assign chk_en    = smp_valid && lock_live;

    // Advance from the expected value once locked, otherwise seed from data.
    assign base = lock_live ? exp_word : smp_data;

    always_comb begin
        unique case (pat_sel)
            PAT_ALT:   nxt = ~base;
            PAT_RAMP:  nxt = base + SAMPLE_W'(1);
            PAT_CONST: nxt = fixed_word;
            PAT_WALK:  nxt = {base[SAMPLE_W-2:0], base[SAMPLE_W-1]};
            default:   nxt = base;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            pat_q    <= PAT_ALT;
            exp_q    <= '0;
        end else begin
            pat_q <= pat_sel;
            if (smp_valid) begin
                exp_q    <= nxt;
                locked_q <= 1'b1;
            end else if (pat_sel != pat_q) begin
                locked_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_err_accum.sv
module adc_err_accum #(
    parameter int SAMPLE_W = 14,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chk_en,
    input  logic [SAMPLE_W-1:0] diff,
    input  logic                clr,
    output logic                mismatch,
    output logic [SAMPLE_W-1:0] err_mask,
    output logic [CNT_W-1:0]    err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [SAMPLE_W-1:0] hit_bits;
    logic                hit;

    assign hit_bits = chk_en ? diff : '0;
    assign hit      = |hit_bits;

    always_ff @(posedge clk) begin
        if (rst) mismatch <= 1'b0;
        else     mismatch <= hit;
    end

    for (genvar b = 0; b < SAMPLE_W; b++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst || clr)       err_mask[b] <= 1'b0;
            else if (hit_bits[b]) err_mask[b] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)                      err_count <= '0;
        else if (hit && err_count != CNT_MAX) err_count <= err_count + CNT_W'(1);
    end

endmodule

// File: rtl/adc_pattern_checker.sv
module adc_pattern_checker
    import adc_pat_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int CNT_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PAT_SEL_W-1:0] pat_sel,
    input  logic [SAMPLE_W-1:0]  fixed_word,
    input  logic                 smp_valid,
    input  logic [SAMPLE_W-1:0]  smp_data,
    input  logic                 clr,
    output logic                 mismatch,
    output logic [SAMPLE_W-1:0]  err_mask,
    output logic [CNT_W-1:0]     err_count
);

    logic                chk_en;
    logic [SAMPLE_W-1:0] exp_word;
    logic [SAMPLE_W-1:0] diff;

    adc_pat_expect #(.SAMPLE_W(SAMPLE_W)) u_expect (
        .clk        (clk),
        .rst        (rst),
        .pat_sel    (pat_e'(pat_sel)),
        .fixed_word (fixed_word),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .chk_en     (chk_en),
        .exp_word   (exp_word)
    );

    assign diff = smp_data ^ exp_word;

    adc_err_accum #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .chk_en    (chk_en),
        .diff      (diff),
        .clr       (clr),
        .mismatch  (mismatch),
        .err_mask  (err_mask),
        .err_count (err_count)
    );

endmodule

// File: rtl/adc_pattern_checker_sva.sv
module adc_pattern_checker_sva #(
    parameter int SAMPLE_W = 14,
    parameter int CNT_W    = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_valid,
    input logic                clr,
    input logic                mismatch,
    input logic [SAMPLE_W-1:0] err_mask,
    input logic [CNT_W-1:0]    err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R8: mask bits never drop without a clear
    a_r8_mask_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (($past(err_mask) & ~err_mask) == '0));

    // R9: counter holds at its ceiling
    a_r9_count_saturates: assert property (@(posedge clk) disable iff (rst)
        (!clr && err_count == CNT_MAX) |=> (err_count == CNT_MAX));

    // R9: count steps by at most one, only with a mismatch
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((err_count == $past(err_count)) ||
                  (mismatch && err_count == $past(err_count) + CNT_W'(1))));

    // R10: clear empties mask and count
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (err_count == '0 && err_mask == '0));

    // R7, R12: no mismatch without a sample
    a_r7_no_sample_no_flag: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !mismatch);

endmodule

bind adc_pattern_checker adc_pattern_checker_sva #(
    .SAMPLE_W(SAMPLE_W),
    .CNT_W   (CNT_W)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .clr       (clr),
    .mismatch  (mismatch),
    .err_mask  (err_mask),
    .err_count (err_count)
);

// File: tb/sim_adc_pattern_checker.sv
module sim_adc_pattern_checker;

    localparam int W  = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    pat_sel;
    logic [W-1:0]  fixed_word;
    logic          smp_valid;
    logic [W-1:0]  smp_data;
    logic          clr;
    logic          mismatch;
    logic [W-1:0]  err_mask;
    logic [CW-1:0] err_count;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    adc_pattern_checker #(.SAMPLE_W(W), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .pat_sel(pat_sel), .fixed_word(fixed_word),
        .smp_valid(smp_valid), .smp_data(smp_data), .clr(clr),
        .mismatch(mismatch), .err_mask(err_mask), .err_count(err_count)
    );

    typedef struct packed {
        logic [1:0]   sel;
        logic         v;
        logic [W-1:0] d;
        logic         mm;
        logic [W-1:0] mask;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b1, 8'h55, 1'b0, 8'h00}, // R2 seed
        '{2'd0, 1'b1, 8'hAA, 1'b0, 8'h00}, // R3
        '{2'd0, 1'b1, 8'h55, 1'b0, 8'h00}, // R3
        '{2'd0, 1'b0, 8'h00, 1'b0, 8'h00}, // R12 idle
        '{2'd0, 1'b1, 8'hAA, 1'b0, 8'h00}, // R12 no advance
        '{2'd0, 1'b1, 8'h57, 1'b1, 8'h02}, // R7 R8 sparkle
        '{2'd0, 1'b1, 8'hAA, 1'b0, 8'h02}, // R11 lock kept
        '{2'd1, 1'b1, 8'hFE, 1'b0, 8'h02}, // R2 reseed on change
        '{2'd1, 1'b1, 8'hFF, 1'b0, 8'h02}, // R4
        '{2'd1, 1'b1, 8'h00, 1'b0, 8'h02}, // R4 wrap
        '{2'd1, 1'b1, 8'h01, 1'b0, 8'h02}, // R4
        '{2'd1, 1'b1, 8'h02, 1'b0, 8'h02}, // R4
        '{2'd1, 1'b1, 8'h07, 1'b1, 8'h06}, // R8 bit2 early
        '{2'd1, 1'b1, 8'h04, 1'b0, 8'h06}, // R11
        '{2'd2, 1'b1, 8'h00, 1'b0, 8'h06}, // R2 seed
        '{2'd2, 1'b1, 8'hA5, 1'b0, 8'h06}, // R5
        '{2'd2, 1'b1, 8'hA4, 1'b1, 8'h07}, // R5 R8
        '{2'd3, 1'b1, 8'h10, 1'b0, 8'h07}, // R2 seed
        '{2'd3, 1'b1, 8'h20, 1'b0, 8'h07}, // R6
        '{2'd3, 1'b1, 8'h40, 1'b0, 8'h07}, // R6
        '{2'd3, 1'b1, 8'h80, 1'b0, 8'h07}, // R6
        '{2'd3, 1'b1, 8'h01, 1'b0, 8'h07}, // R6 wrap
        '{2'd3, 1'b1, 8'h82, 1'b1, 8'h87}, // R6 R8
        '{2'd3, 1'b1, 8'h04, 1'b0, 8'h87}  // R11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] s, input logic v, input logic [W-1:0] d, input logic c);
        @(negedge clk);
        pat_sel = s; smp_valid = v; smp_data = d; clr = c;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1; pat_sel = 2'd0; fixed_word = 8'hA5;
        smp_valid = 1'b0; smp_data = '0; clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 mismatch", 32'(mismatch), 0);
        chk("R1 mask", 32'(err_mask), 0);
        chk("R1 count", 32'(err_count), 0);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].sel, TBL[i].v, TBL[i].d, 1'b0);
            chk($sformatf("R7 row%0d mismatch", i), 32'(mismatch), 32'(TBL[i].mm));
            chk($sformatf("R8 row%0d mask", i), 32'(err_mask), 32'(TBL[i].mask));
        end
        chk("R9 count after table", 32'(err_count), 4);

        // R10: clear wins over a mismatching sample; expected 08, send 00
        step(2'd3, 1'b1, 8'h00, 1'b1);
        chk("R10 mismatch still flagged", 32'(mismatch), 1);
        chk("R10 mask cleared", 32'(err_mask), 0);
        chk("R10 count cleared", 32'(err_count), 0);
        step(2'd3, 1'b1, 8'h10, 1'b0);
        chk("R10 lock kept", 32'(mismatch), 0);

        // R9 saturation in constant mode
        step(2'd2, 1'b1, 8'h00, 1'b0);
        chk("R2 seed const", 32'(mismatch), 0);
        for (int k = 0; k < 20; k++) step(2'd2, 1'b1, 8'h00, 1'b0);
        chk("R9 saturated", 32'(err_count), 15);
        chk("R5 mask", 32'(err_mask), 32'hA5);
        step(2'd2, 1'b0, 8'h00, 1'b0);
        chk("R12 idle no flag", 32'(mismatch), 0);
        chk("R9 held", 32'(err_count), 15);

        // R1 R2 reset mid-run then seed
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 count after reset", 32'(err_count), 0);
        chk("R1 mask after reset", 32'(err_mask), 0);
        step(2'd2, 1'b1, 8'h00, 1'b0);
        chk("R2 seed after reset", 32'(mismatch), 0);
        step(2'd2, 1'b1, 8'h00, 1'b0);
        chk("R5 checked after seed", 32'(mismatch), 1);
        chk("R9 one error", 32'(err_count), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule